// File: doc/BRIEF.md
# Dual-Source Counter Interrupt Generator

An 8-bit down-counter raises an active-low interrupt request. The counter advances on one of two sources. In scanline mode the source is a filtered rising edge of the video address line A12. In cycle mode it is a divide-by-four of the CPU bus clock M2. Software-visible state is held in four write strobes that an external decoder has already produced. These are a reload-value latch, a mode/reload trigger, an interrupt disable/acknowledge and an interrupt enable. All of them share one 8-bit data bus.

M2 and A12 are asynchronous pins. Both pass through the same synchronizer chain, so they stay aligned. Every event is keyed to a falling edge of M2 seen in the system-clock domain. Once the counter lands on zero with interrupts enabled, the request asserts four M2 falls later. It then stays asserted until software acknowledges it.

Top module: `irq_line_timer`

## Requirements
- R1: After reset the request output is high (inactive) and interrupts are disabled, so the counter reaching zero raises nothing until an enable write.
- R2: In cycle mode (mode bit 0 = 1) the counter is clocked on every fourth M2 fall. A reload write clears the prescaler, so the first clock comes on the fourth M2 fall after that write.
- R3: On a counter clock with a reload pending, the counter takes the latch value ORed with 1 (or 0 if the latch is 0) and is then decremented. The pending flag clears.
- R4: On a counter clock with no reload pending, a counter at 0 takes the latch value unmodified and is then decremented. The decrement wraps in 8 bits, so latch 0 yields 255.
- R5: When a counter clock leaves the counter at 0 and interrupts are enabled, the request asserts on the fourth M2 fall after the fall that carried that clock.
- R6: In scanline mode (mode bit 0 = 0) a filter counts M2 falls with A12 low and saturates at 16. A fall with A12 high clocks the counter only if the filter reads 16, and it always clears the filter.
- R7: A reload write sets the scanline filter to 17. The first A12-high fall after it therefore never clocks the counter. Lines shorter than 16 low falls never clock it either.
- R8: A disable write clears the enable, clears an asserted request and cancels a request still in its delay.
- R9: An enable write sets the enable without clearing an asserted request. The request stays asserted until a disable write.
- R10: A latch write stores the 8-bit reload value. A reload write stores data bit 0 as the clock-source mode and marks a reload pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_latch_i | input | 1 | Strobe: load reload latch from data |
| wr_reload_i | input | 1 | Strobe: set mode from data bit 0, request reload |
| wr_disable_i | input | 1 | Strobe: disable and acknowledge |
| wr_enable_i | input | 1 | Strobe: enable interrupts |
| wr_data_i | input | 8 | Write data |
| m2_i | input | 1 | CPU bus clock, asynchronous |
| a12_i | input | 1 | Video address line A12, asynchronous |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The hardest state to reach from the ports is a counter clock that arrives while an earlier request is still counting its four-fall delay. A close second is a zero-reload that must skip the OR-with-1 rule. Both states exist only a few M2 falls after a prior zero crossing. The stimulus walks M2 one cycle at a time and drives A12 from a per-fall pattern. It then places disable, enable and reload writes between specific falls. One sequence is a disable just after an armed delay, which must push the request out by a full counter period. Another is an acknowledge right after the first request with latch 2, which separates 24 from 28 falls. The scanline cases include lines of exactly 15 and 16 low falls, which sit on either side of the filter threshold.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;
  typedef enum logic {
    SRC_SCANLINE = 1'b0,
    SRC_CYCLE    = 1'b1
  } src_mode_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_source.sv
module clk_source
  import irq_tmr_pkg::*;
#(
  parameter int PRESC_DIV  = 4,
  parameter int FILT_LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic m2_s_i,
  input  logic a12_s_i,
  input  logic wr_reload_i,
  input  logic mode_d_i,
  output logic fall_o,
  output logic tick_o
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int FW = $clog2(FILT_LIMIT + 2);
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);
  localparam logic [FW-1:0] FILT_FULL  = FW'(FILT_LIMIT);
  localparam logic [FW-1:0] FILT_ARM   = FW'(FILT_LIMIT + 1);

  src_mode_e       mode_q;
  logic            m2_prev_q;
  logic [PW-1:0]   presc_q;
  logic [FW-1:0]   filt_q;
  logic            tick_cyc, tick_scan;

  assign fall_o    = m2_prev_q & ~m2_s_i;
  assign tick_cyc  = fall_o && (presc_q == PRESC_LAST);
  assign tick_scan = fall_o && a12_s_i && (filt_q == FILT_FULL);
  // a reload write restarts the source, so no clock in that cycle
  assign tick_o    = !wr_reload_i && ((mode_q == SRC_CYCLE) ? tick_cyc : tick_scan);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= SRC_SCANLINE;
      m2_prev_q <= 1'b0;
      presc_q   <= '0;
      filt_q    <= '0;
    end else begin
      m2_prev_q <= m2_s_i;
      if (wr_reload_i) begin
        mode_q  <= src_mode_e'(mode_d_i);
        presc_q <= '0;
        filt_q  <= FILT_ARM;
      end else if (fall_o) begin
        presc_q <= (presc_q == PRESC_LAST) ? '0 : presc_q + PW'(1);
        if (a12_s_i)                filt_q <= '0;
        else if (filt_q < FILT_FULL) filt_q <= filt_q + FW'(1);
      end
    end
  end

  a_r2_presc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reload_i |=> presc_q == '0);
  a_r7_filter_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reload_i |=> filt_q == FILT_ARM);
  a_r6_filter_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_q <= FILT_ARM);
  a_r6_high_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o && a12_s_i && !wr_reload_i |=> filt_q == '0);
endmodule

// File: rtl/irq_core.sv
module irq_core #(
  parameter int CNT_W     = 8,
  parameter int IRQ_DELAY = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             wr_latch_i,
  input  logic             wr_reload_i,
  input  logic             wr_disable_i,
  input  logic             wr_enable_i,
  input  logic [CNT_W-1:0] data_i,
  output logic             irq_o
);
  localparam int DW = $clog2(IRQ_DELAY + 1);
  localparam logic [DW-1:0] DLY_LOAD = DW'(IRQ_DELAY);

  logic [CNT_W-1:0] latch_q, cnt_q, base, cnt_next;
  logic             pend_q, en_q, irq_q, zero_hit;
  logic [DW-1:0]    dly_q;

  always_comb begin
    if (pend_q)              base = (latch_q != '0) ? (latch_q | CNT_W'(1)) : '0;
    else if (cnt_q == '0)    base = latch_q;
    else                     base = cnt_q;
    cnt_next = base - CNT_W'(1);
  end

  assign zero_hit = tick_i && (cnt_next == '0) && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      dly_q   <= '0;
    end else begin
      if (wr_latch_i)       latch_q <= data_i;
      if (wr_reload_i)      pend_q  <= 1'b1;
      else if (tick_i)      pend_q  <= 1'b0;
      if (tick_i)           cnt_q   <= cnt_next;
      if (wr_disable_i)     en_q    <= 1'b0;
      else if (wr_enable_i) en_q    <= 1'b1;
      if (wr_disable_i) begin
        irq_q <= 1'b0;
        dly_q <= '0;
      end else begin
        if (fall_i && dly_q == DW'(1)) irq_q <= 1'b1;
        if (zero_hit)                    dly_q <= DLY_LOAD;
        else if (fall_i && dly_q != '0)  dly_q <= dly_q - DW'(1);
      end
    end
  end

  assign irq_o = irq_q;

  a_r8_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_disable_i |=> !irq_q && !en_q && dly_q == '0);
  a_r9_request_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !wr_disable_i |=> irq_q);
  a_r5_rise_after_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(dly_q) == DW'(1) && $past(fall_i));
  a_r3_pending_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && pend_q && latch_q != '0 |=> cnt_q == ($past(latch_q) | CNT_W'(1)) - CNT_W'(1));
  a_r4_zero_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !pend_q && cnt_q == '0 |=> cnt_q == $past(latch_q) - CNT_W'(1));
endmodule

// File: rtl/irq_line_timer.sv
module irq_line_timer #(
  parameter int CNT_W       = 8,
  parameter int PRESC_DIV   = 4,
  parameter int FILT_LIMIT  = 16,
  parameter int IRQ_DELAY   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_latch_i,
  input  logic             wr_reload_i,
  input  logic             wr_disable_i,
  input  logic             wr_enable_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             m2_i,
  input  logic             a12_i,
  output logic             irq_no
);
  logic [1:0] pins_s;
  logic       fall, tick, irq;

  // both pins share one chain so A12 stays aligned with M2
  pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({a12_i, m2_i}), .q_o(pins_s)
  );

  clk_source #(.PRESC_DIV(PRESC_DIV), .FILT_LIMIT(FILT_LIMIT)) u_src (
    .clk_i, .rst_ni,
    .m2_s_i(pins_s[0]), .a12_s_i(pins_s[1]),
    .wr_reload_i, .mode_d_i(wr_data_i[0]),
    .fall_o(fall), .tick_o(tick)
  );

  irq_core #(.CNT_W(CNT_W), .IRQ_DELAY(IRQ_DELAY)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .fall_i(fall),
    .wr_latch_i, .wr_reload_i, .wr_disable_i, .wr_enable_i,
    .data_i(wr_data_i), .irq_o(irq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~irq;
  end
endmodule

// File: tb/irq_line_timer_test.sv
module irq_line_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_latch = 0, wr_reload = 0, wr_disable = 0, wr_enable = 0;
  logic [7:0] wr_data = '0;
  logic       m2 = 0, a12 = 0;
  logic       irq_n;
  int         n_chk = 0, n_bad = 0;
  int         cyc = 0;

  always #4 clk = ~clk;

  irq_line_timer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_latch_i(wr_latch), .wr_reload_i(wr_reload),
    .wr_disable_i(wr_disable), .wr_enable_i(wr_enable),
    .wr_data_i(wr_data), .m2_i(m2), .a12_i(a12), .irq_no(irq_n)
  );

  // columns: mode, latch, low falls per line, expected fall of request (0 = none), fall limit
  localparam int VEC [10][5] = '{
    '{1, 1,   0,    8,   40},  // R2 R3 R5
    '{1, 2,   0,   16,   40},  // R3
    '{1, 3,   0,   16,   40},  // R3
    '{1, 4,   0,   24,   60},  // R3
    '{1, 0,   0, 1028, 1100},  // R4 wrap
    '{0, 1,  16,   38,   80},  // R6 R7
    '{0, 3,  20,   88,  120},  // R6 R3
    '{0, 1,  15,    0,  120},  // R7 short lines
    '{0, 1,  40,   86,  120},  // R6 saturation
    '{0, 1, 100,    0,   60}   // R10 scanline ignores bare M2
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int sel, input int d);
    @(negedge clk);
    wr_data = 8'(d);
    case (sel)
      0: wr_latch = 1;
      1: wr_reload = 1;
      2: wr_disable = 1;
      default: wr_enable = 1;
    endcase
    @(negedge clk);
    {wr_latch, wr_reload, wr_disable, wr_enable} = '0;
  endtask

  task automatic m2_cycle(input logic a);
    @(negedge clk);
    a12 = a;
    m2 = 1;
    repeat (4) @(negedge clk);
    m2 = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input int mode, input int lw, input int max, output int idx);
    idx = 0;
    for (int i = 1; i <= max; i++) begin
      m2_cycle((mode == 0) && (((i - 1) % (lw + 1)) == lw));
      if (irq_n == 1'b0) begin
        idx = i;
        break;
      end
    end
    a12 = 0;
  endtask

  task automatic setup(input int mode, input int latch, input bit en);
    strobe(2, 0);
    strobe(0, latch);
    strobe(1, mode);
    if (en) strobe(3, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(irq_n), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle output", int'(irq_n), 1);

    // R1: no enable after reset, zero crossings raise nothing
    strobe(0, 1);
    strobe(1, 1);
    run(1, 0, 40, idx);
    check("R1 disabled after reset", idx, 0);

    for (int v = 0; v < 10; v++) begin
      setup(VEC[v][0], VEC[v][1], 1);
      run(VEC[v][0], VEC[v][2], VEC[v][4], idx);
      check($sformatf("R5 vector %0d fall index", v), idx, VEC[v][3]);
    end

    // R9: request held, enable does not acknowledge; R8: disable does
    setup(1, 1, 1);
    run(1, 0, 40, idx);
    check("R5 cycle latch 1", idx, 8);
    repeat (6) m2_cycle(0);
    check("R9 held across falls", int'(irq_n), 0);
    strobe(3, 0);
    @(negedge clk);
    check("R9 enable keeps request", int'(irq_n), 0);
    strobe(2, 0);
    @(negedge clk);
    check("R8 disable acknowledges", int'(irq_n), 1);

    // R2: reload mid-prescale restarts the four-fall count
    setup(1, 1, 1);
    repeat (2) m2_cycle(0);
    strobe(1, 1);
    run(1, 0, 40, idx);
    check("R2 prescaler cleared by reload", idx, 8);

    // R8: disable during the delay cancels it
    setup(1, 1, 1);
    repeat (5) m2_cycle(0);
    strobe(2, 0);
    strobe(3, 0);
    run(1, 0, 40, idx);
    check("R8 delay cancelled", idx, 7);

    // R4: zero-reload skips the OR with 1
    setup(1, 2, 1);
    run(1, 0, 40, idx);
    check("R3 latch 2 first request", idx, 16);
    strobe(2, 0);
    strobe(3, 0);
    run(1, 0, 40, idx);
    check("R4 plain zero reload", idx, 8);

    // R10: latch rewritten while a reload pends takes effect on the first clock
    setup(1, 9, 1);
    strobe(0, 4);
    run(1, 0, 60, idx);
    check("R10 latest latch value used", idx, 24);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule